// File: doc/BRIEF.md
# Event-Driven PC Sampling Histogram

This block builds a statistical profile of where a program spends its time, or where a chosen hardware event happens. Each cycle it may see one strobe of a selected event: a timer tick for time-based profiling, or a hardware event such as a floating-point operation for event-based profiling. A sample counter starts at minus the sampling threshold and counts up by one on each strobe. When the counter wraps, the block takes the program counter presented in that same cycle. It maps that value to a bucket, where each bucket covers one fixed-size block of instruction addresses. It then adds one to that bucket in an on-chip table and reloads the counter.

The window of addresses covered is set by a base address and a block-size shift. Samples that fall outside the window are tallied in a separate out-of-range counter. A bucket update is a two-cycle read-modify-write. One further sample that arrives during an update is held in a single pending slot. A sample that arrives while both the update and the slot are occupied is discarded. Software empties the table through a registered read port. Before a new run it pulses a clear, which walks the table one entry per cycle while `busy` is high.

Top module: `pc_sample_hist`

## Requirements
- R1: After reset, and after any cycle in which `clr` is sampled high, `busy` stays high for exactly DEPTH cycles. When it falls, every bucket and `oor_count` read zero.
- R2: The sample counter is loaded with minus `thresh` whenever `busy` is high, and again at every sample. The `thresh`-th qualifying strobe after a load produces exactly one sample. A qualifying strobe is a cycle with `evt`=1, `en`=1 and `busy`=0.
- R3: A strobe with `en` low, or one that arrives while `busy` is high, does not advance the sample counter. It changes no bucket and does not change `oor_count`.
- R4: A sample uses the `pc` of its own cycle. It adds one to bucket index (`pc` − `base`) >> `shift`, taken as an unsigned value.
- R5: When `pc` < `base`, or when the index is DEPTH or more, the sample adds one to `oor_count` and no bucket changes.
- R6: Buckets and `oor_count` saturate at 2^BKT_W − 1 and never wrap.
- R7: A bucket update takes two cycles. With `thresh` = 1, three qualifying strobes on consecutive cycles are all recorded: the first is updated at once, and the other two pass through the one-deep pending slot.
- R8: `rd_data` gives the bucket selected by `rd_idx` one cycle after `rd_idx` is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; starts a clear walk |
| en | input | 1 | Counting enable |
| clr | input | 1 | Starts a clear walk; also drops any sample in flight |
| evt | input | 1 | Selected event strobe, at most one per cycle |
| pc | input | PC_W | Current program counter |
| thresh | input | CNT_W | Sampling threshold, 1 or more |
| base | input | PC_W | Lowest address covered by the table |
| shift | input | SH_W | log2 of the bytes per bucket |
| rd_idx | input | IDX_W | Bucket selected for readout |
| rd_data | output | BKT_W | Registered bucket value |
| busy | output | 1 | Clear walk in progress |
| oor_count | output | BKT_W | Saturating count of out-of-range samples |

## Verification
The bench aims at the edges of the counting window. It drives strobes while the clear walk runs and while `en` is low, then checks that one strobe short of the threshold still leaves the bucket at zero. A design that counted those ignored strobes would show the increment early. Addresses just below `base` and one block past the top bucket must land in `oor_count`; a careless index calculation would alias them into bucket 0 or bucket 15. A burst at threshold 1 stresses the pending slot, where a missing slot would lose a sample. A long run at threshold 2 pushes a bucket and the out-of-range counter past 255, where a wrapping design would read a small value.

// File: rtl/pc_sample_hist.sv
module pc_sample_hist #(
  parameter int PC_W  = 32,
  parameter int CNT_W = 16,
  parameter int BKT_W = 8,
  parameter int DEPTH = 16,
  parameter int SH_W  = 5,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic             evt,
  input  logic [PC_W-1:0]  pc,
  input  logic [CNT_W-1:0] thresh,
  input  logic [PC_W-1:0]  base,
  input  logic [SH_W-1:0]  shift,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [BKT_W-1:0] rd_data,
  output logic             busy,
  output logic [BKT_W-1:0] oor_count
);
  localparam logic [1:0] IDLE = 2'd0, RD = 2'd1, WR = 2'd2;

  logic [BKT_W-1:0] mem [DEPTH];
  logic [BKT_W-1:0] rd_q;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] a_idx, p_idx, clr_ptr;
  logic [1:0]       ph;
  logic             pend_v;

  wire [PC_W-1:0]  off    = pc - base;
  wire [PC_W-1:0]  blk    = off >> shift;
  wire             in_rng = (pc >= base) && (blk < PC_W'(DEPTH));
  wire [IDX_W-1:0] s_idx  = blk[IDX_W-1:0];
  wire             hit    = en && evt && !busy && (cnt == '1);
  wire             req    = hit && in_rng;
  wire             free   = (ph != RD);
  wire [BKT_W-1:0] inc    = (rd_q == '1) ? rd_q : rd_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b1;
      clr_ptr   <= '0;
      cnt       <= '0;
      ph        <= IDLE;
      pend_v    <= 1'b0;
      a_idx     <= '0;
      p_idx     <= '0;
      oor_count <= '0;
    end else if (clr) begin
      busy      <= 1'b1;
      clr_ptr   <= '0;
      cnt       <= -thresh;
      ph        <= IDLE;
      pend_v    <= 1'b0;
      oor_count <= '0;
    end else if (busy) begin
      cnt     <= -thresh;
      clr_ptr <= clr_ptr + 1'b1;
      if (clr_ptr == IDX_W'(DEPTH - 1)) busy <= 1'b0;
    end else begin
      if (en && evt) cnt <= hit ? -thresh : cnt + 1'b1;
      if (hit && !in_rng && oor_count != '1) oor_count <= oor_count + 1'b1;
      if (free) begin
        if (pend_v) begin
          a_idx  <= p_idx;
          ph     <= RD;
          pend_v <= req;
          if (req) p_idx <= s_idx;
        end else if (req) begin
          a_idx <= s_idx;
          ph    <= RD;
        end else begin
          ph <= IDLE;
        end
      end else begin
        ph <= WR;
        if (req && !pend_v) begin
          pend_v <= 1'b1;
          p_idx  <= s_idx;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (busy) mem[clr_ptr] <= '0;
    else if (ph == WR && !clr) mem[a_idx] <= inc;
    if (ph == RD) rd_q <= mem[a_idx];
    rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/pc_sample_hist_chk.sv
module pc_sample_hist_chk #(
  parameter int DEPTH = 16,
  parameter int BKT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             en,
  input logic             busy,
  input logic [BKT_W-1:0] oor_count,
  input logic [1:0]       ph,
  input logic             pend_v
);
  int unsigned run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= 0;
    else if (clr || !busy) run <= 0;
    else run <= run + 1;
  end

  p_busy_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run < DEPTH);

  p_no_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr && !busy) |=> $stable(oor_count));

  p_oor_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !clr) |=> (oor_count == $past(oor_count)) ||
                        (oor_count == $past(oor_count) + 1'b1));

  p_oor_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (oor_count == '1 && !clr) |=> oor_count == '1);

  p_rmw_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == 2'd1 && !clr) |=> ph == 2'd2);

  p_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pend_v |-> ph != 2'd0);
endmodule

bind pc_sample_hist pc_sample_hist_chk #(.DEPTH(DEPTH), .BKT_W(BKT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .en(en), .busy(busy),
  .oor_count(oor_count), .ph(ph), .pend_v(pend_v)
);

// File: tb/pc_sample_hist_bench.sv
module pc_sample_hist_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b1, clr = 1'b0, evt = 1'b0;
  logic [31:0] pc = '0, base = 32'h1000;
  logic [15:0] thresh = 16'd4;
  logic [4:0]  shift = 5'd4;
  logic [3:0]  rd_idx = '0;
  logic [7:0]  rd_data, oor_count;
  logic        busy;

  int checks = 0, fails = 0;
  int mdl [16];
  int moor = 0, mc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pc_sample_hist u_pc_sample_hist (
    .clk(clk), .rst_n(rst_n), .en(en), .clr(clr), .evt(evt), .pc(pc),
    .thresh(thresh), .base(base), .shift(shift), .rd_idx(rd_idx),
    .rd_data(rd_data), .busy(busy), .oor_count(oor_count)
  );

  localparam logic [39:0] VEC [8] = '{
    {32'h0000_1000, 8'd4}, {32'h0000_1014, 8'd8}, {32'h0000_10F8, 8'd6},
    {32'h0000_1100, 8'd5}, {32'h0000_0FFC, 8'd4}, {32'h0000_1024, 8'd9},
    {32'h0000_1000, 8'd3}, {32'h0000_10F0, 8'd4}
  };

  function automatic int bidx(logic [31:0] p);
    logic [31:0] b;
    if (p < base) return -1;
    b = (p - base) >> shift;
    return (b < 16) ? int'(b) : -1;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 16; i++) mdl[i] = 0;
    moor = 0;
    mc = 0;
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic ev(logic [31:0] p, int n, bit modelled);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      evt = 1'b1;
      pc = p;
      if (modelled) begin
        mc++;
        if (mc == int'(thresh)) begin
          mc = 0;
          if (bidx(p) < 0) begin
            if (moor < 255) moor++;
          end else if (mdl[bidx(p)] < 255) mdl[bidx(p)]++;
        end
      end
    end
    @(negedge clk);
    evt = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic rd(int idx, output int v);
    @(negedge clk);
    rd_idx = idx[3:0];
    @(negedge clk);
    v = int'(rd_data);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic do_clear(bit strobe);
    int n;
    @(negedge clk);
    clr = 1'b1;
    evt = strobe;
    @(negedge clk);
    clr = 1'b0;
    busy_len(n);
    evt = 1'b0;
    chk("R1 busy cycles after clr", n, 16);
    model_clear();
  endtask

  initial begin
    int n, v;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    busy_len(n);
    chk("R1 busy cycles after reset", n, 16);
    for (int i = 0; i < 16; i++) begin
      rd(i, v);
      chk("R1 bucket zero after reset", v, 0);
    end
    chk("R1 oor zero after reset", int'(oor_count), 0);

    for (int i = 0; i < 8; i++) begin
      ev(VEC[i][39:8], int'(VEC[i][7:0]), 1'b1);
      if (bidx(VEC[i][39:8]) < 0)
        chk("R5 out-of-range count", int'(oor_count), moor);
      else begin
        rd(bidx(VEC[i][39:8]), v);
        chk("R4 bucket after vector", v, mdl[bidx(VEC[i][39:8])]);
      end
    end
    for (int i = 0; i < 16; i++) begin
      rd(i, v);
      chk("R8 readout of every bucket", v, mdl[i]);
    end

    do_clear(1'b1);
    chk("R1 oor zero after clr", int'(oor_count), 0);
    ev(32'h1000, 3, 1'b1);
    rd(0, v);
    chk("R3 strobes during walk ignored / R2 below threshold", v, 0);
    ev(32'h1000, 1, 1'b1);
    rd(0, v);
    chk("R2 threshold reached", v, 1);
    en = 1'b0;
    ev(32'h1000, 10, 1'b0);
    en = 1'b1;
    ev(32'h1000, 3, 1'b1);
    rd(0, v);
    chk("R3 strobes with en low ignored", v, 1);
    ev(32'h1000, 1, 1'b1);
    rd(0, v);
    chk("R2 next sample after reload", v, 2);

    shift = 5'd0;
    ev(32'h1005, 4, 1'b1);
    rd(5, v);
    chk("R4 shift 0 index", v, 1);
    shift = 5'd2;
    ev(32'h1030, 4, 1'b1);
    rd(12, v);
    chk("R4 shift 2 index", v, 1);

    thresh = 16'd1;
    do_clear(1'b0);
    @(negedge clk); evt = 1'b1; pc = 32'h101C;
    @(negedge clk); pc = 32'h1020;
    @(negedge clk); pc = 32'h1024;
    @(negedge clk); evt = 1'b0;
    repeat (6) @(negedge clk);
    rd(7, v); chk("R7 first of burst", v, 1);
    rd(8, v); chk("R7 pending sample", v, 1);
    rd(9, v); chk("R7 third of burst", v, 1);

    thresh = 16'd2;
    do_clear(1'b0);
    ev(32'h1004, 600, 1'b1);
    ev(32'h2000, 600, 1'b1);
    rd(1, v);
    chk("R6 bucket saturates", v, 255);
    chk("R6 oor saturates", int'(oor_count), 255);
    rd(0, v);
    chk("R6 neighbour untouched", v, 0);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule